// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit runs the second byte of a two-byte prefixed instruction on an 8-bit processor core. After the core has fetched the prefix and the following opcode byte, it pulses `start` with that byte and the current flag values. The unit decodes the byte and gets the operand. The operand is either one of eight general registers, read through a combinational register-file port, or the memory byte that a 16-bit pointer register addresses, read through a request/acknowledge memory port. The unit then applies one operation from one of four groups: a shift, rotate or nibble swap; a bit test; a bit clear; or a bit set. It writes the result back where it is needed.

When the operation is complete, the unit raises `done` for one cycle. During that cycle `flags_out` holds the updated zero/subtract/half-carry/carry flags and `cycles` holds the machine-cycle cost of the instruction. The core uses this cost for its own timing accounting.

Top module: `bitop_exec`

## Requirements
- R1: Opcode bits 2:0 select the operand. Index 6 selects the memory byte at the pointer address. Any other index selects the register with that index. A register operation touches no memory, and a memory operation leaves the registers unchanged.
- R2: Opcode bits 7:6 select the group: 00 is shift/rotate, 01 is bit test, 10 is bit clear, 11 is bit set. For the last three groups, bits 5:3 give the bit index.
- R3: In group 00, a sub-op value of 0 (bits 5:3) rotates left and a value of 1 rotates right. In both cases the bit shifted out goes to carry and to the vacated end. A value of 2 rotates left through carry and a value of 3 rotates right through carry: the old carry fills the vacated end.
- R4: In group 00, a sub-op value of 4 shifts left and fills with zero. A value of 5 shifts right and keeps bit 7. A value of 7 shifts right and fills with zero. A value of 6 exchanges the two nibbles.
- R5: The flags are packed as {Z,N,H,C} in bits 3..0. Every group-00 operation sets Z when the 8-bit result is zero and clears N and H. C takes the bit shifted out; for the nibble swap, C is cleared.
- R6: A bit test sets Z to the inverse of the selected bit, clears N, sets H and keeps C. It performs no write of any kind.
- R7: A bit clear or bit set changes only the selected bit. It keeps all four flags and writes the result back to the operand location.
- R8: `cycles` reports 2 for a register operand, 3 for a bit test on the memory operand, and 4 for any other memory-operand operation.
- R9: The memory write-back uses the address captured at `start`, even if `ptr` changes during the operation. `mem_addr` stays steady while a request is pending.
- R10: `busy` is high from an accepted `start` until `done`. `done` is a one-cycle pulse. A `start` that arrives while the unit is busy is ignored.
- R11: While the unit is in reset or idle, `busy` and `done` are low and no memory request or register write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accepts `opcode` and `flags_in` when idle |
| opcode | input | 8 | Second instruction byte |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| ptr | input | 16 | Pointer register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flags_out | output | 4 | Updated flags, valid with `done` |
| cycles | output | 3 | Machine-cycle cost, valid with `done` |
| rf_raddr | output | 3 | Register read index |
| rf_rdata | input | 8 | Register read data (combinational) |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 8 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the unit with its default parameters: an 8-bit datapath, a 16-bit pointer and memory index 6. With an 8-bit opcode, every one of the 256 codes can then be exercised. Each code is run with random operands and both carry values. The results, flags, write strobes, addresses and cycle counts are compared against a bench model. Since the pointer is changed while each memory operation is in progress, the address capture is tested on every memory code.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    localparam int DW      = 8;
    localparam int AW      = 16;
    localparam int IDX_W   = 3;
    localparam int CYC_W   = 3;
    localparam logic [IDX_W-1:0] MEM_IDX = 3'd6;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC, SH_RRC, SH_RL, SH_RR, SH_SLA, SH_SRA, SH_SWAP, SH_SRL
    } shop_e;

    typedef enum logic [2:0] {
        S_IDLE, S_REG, S_MRD, S_MWR, S_FIN
    } seq_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        grp_e             grp;
        logic [IDX_W-1:0] sel;
        logic [IDX_W-1:0] src;
        logic             use_mem;
        logic             writes;
        logic [CYC_W-1:0] cycles;
    } dec_t;

    function automatic dec_t decode(input logic [DW-1:0] op);
        dec_t d;
        d.grp     = grp_e'(op[7:6]);
        d.sel     = op[5:3];
        d.src     = op[2:0];
        d.use_mem = (op[2:0] == MEM_IDX);
        d.writes  = (d.grp != GRP_TEST);
        if (!d.use_mem)     d.cycles = CYC_W'(2);
        else if (d.writes)  d.cycles = CYC_W'(4);
        else                d.cycles = CYC_W'(3);
        return d;
    endfunction
endpackage

// File: rtl/bitop_shift.sv
module bitop_shift
    import bitop_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    input  logic [2:0]   sel,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int HALF = W / 2;

    always_comb begin
        res  = d;
        cout = 1'b0;
        case (shop_e'(sel))
            SH_RLC:  begin res = {d[W-2:0], d[W-1]};        cout = d[W-1]; end
            SH_RRC:  begin res = {d[0], d[W-1:1]};          cout = d[0];   end
            SH_RL:   begin res = {d[W-2:0], cin};           cout = d[W-1]; end
            SH_RR:   begin res = {cin, d[W-1:1]};           cout = d[0];   end
            SH_SLA:  begin res = {d[W-2:0], 1'b0};          cout = d[W-1]; end
            SH_SRA:  begin res = {d[W-1], d[W-1:1]};        cout = d[0];   end
            SH_SWAP: begin res = {d[HALF-1:0], d[W-1:HALF]}; cout = 1'b0;  end
            SH_SRL:  begin res = {1'b0, d[W-1:1]};          cout = d[0];   end
            default: begin res = d;                         cout = 1'b0;   end
        endcase
    end
endmodule

// File: rtl/bitop_bitops.sv
module bitop_bitops
    import bitop_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  d,
    input  grp_e          grp,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  res,
    output logic          bit_val
);
    logic [W-1:0] mask;

    always_comb begin
        mask      = '0;
        mask[idx] = 1'b1;
        bit_val   = d[idx];
        res       = (grp == GRP_CLR) ? (d & ~mask) : (d | mask);
    end
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
    import bitop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_mem,
    input  logic writes,
    input  logic mem_ack,
    output logic accept,
    output logic in_reg,
    output logic in_mrd,
    output logic in_mwr,
    output logic in_fin
);
    seq_e st, st_nx;

    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE:  if (start) st_nx = start_mem ? S_MRD : S_REG;
            S_REG:   st_nx = S_FIN;
            S_MRD:   if (mem_ack) st_nx = writes ? S_MWR : S_FIN;
            S_MWR:   if (mem_ack) st_nx = S_FIN;
            S_FIN:   st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= st_nx;
    end

    assign accept = (st == S_IDLE) && start;
    assign in_reg = (st == S_REG);
    assign in_mrd = (st == S_MRD);
    assign in_mwr = (st == S_MWR);
    assign in_fin = (st == S_FIN);
endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
    import bitop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DW-1:0]    opcode,
    input  logic [3:0]       flags_in,
    input  logic [AW-1:0]    ptr,
    output logic             busy,
    output logic             done,
    output logic [3:0]       flags_out,
    output logic [CYC_W-1:0] cycles,
    output logic [IDX_W-1:0] rf_raddr,
    input  logic [DW-1:0]    rf_rdata,
    output logic             rf_we,
    output logic [IDX_W-1:0] rf_waddr,
    output logic [DW-1:0]    rf_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata
);
    logic [DW-1:0] op_q;
    flags_t        flg_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] res_q;
    logic          idle_q;
    dec_t          dec;
    logic          accept, in_reg, in_mrd, in_mwr, in_fin;
    logic [DW-1:0] operand, sh_res, bo_res, res;
    logic          sh_c, bit_val, capture;
    flags_t        flg_nx;

    assign dec = decode(op_q);

    bitop_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_mem (opcode[IDX_W-1:0] == MEM_IDX),
        .writes    (dec.writes),
        .mem_ack   (mem_ack),
        .accept    (accept),
        .in_reg    (in_reg),
        .in_mrd    (in_mrd),
        .in_mwr    (in_mwr),
        .in_fin    (in_fin)
    );

    assign operand = dec.use_mem ? mem_rdata : rf_rdata;

    bitop_shift #(.W(DW)) u_shift (
        .d    (operand),
        .sel  (dec.sel),
        .cin  (flg_q.c),
        .res  (sh_res),
        .cout (sh_c)
    );

    bitop_bitops #(.W(DW)) u_bitops (
        .d       (operand),
        .grp     (dec.grp),
        .idx     (dec.sel),
        .res     (bo_res),
        .bit_val (bit_val)
    );

    always_comb begin
        flg_nx = flg_q;
        res    = operand;
        case (dec.grp)
            GRP_SHIFT: begin
                res      = sh_res;
                flg_nx.z = (sh_res == '0);
                flg_nx.n = 1'b0;
                flg_nx.h = 1'b0;
                flg_nx.c = sh_c;
            end
            GRP_TEST: begin
                res      = operand;
                flg_nx.z = ~bit_val;
                flg_nx.n = 1'b0;
                flg_nx.h = 1'b1;
            end
            default: res = bo_res;
        endcase
    end

    assign capture = in_reg || (in_mrd && mem_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            flg_q  <= '0;
            addr_q <= '0;
            res_q  <= '0;
            idle_q <= 1'b1;
        end else begin
            if (accept) begin
                op_q   <= opcode;
                flg_q  <= flags_t'(flags_in);
                addr_q <= ptr;
                idle_q <= 1'b0;
            end else if (in_fin) begin
                idle_q <= 1'b1;
            end
            if (capture) begin
                flg_q <= flg_nx;
                res_q <= res;
            end
        end
    end

    assign busy      = ~idle_q;
    assign done      = in_fin;
    assign flags_out = flg_q;
    assign cycles    = dec.cycles;
    assign rf_raddr  = dec.src;
    assign rf_waddr  = dec.src;
    assign rf_we     = in_reg && dec.writes;
    assign rf_wdata  = res;
    assign mem_req   = in_mrd || in_mwr;
    assign mem_we    = in_mwr;
    assign mem_addr  = addr_q;
    assign mem_wdata = res_q;
endmodule

// File: rtl/bitop_exec_chk.sv
module bitop_exec_chk
    import bitop_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic             rf_we,
    input logic [DW-1:0]    op_q,
    input logic [CYC_W-1:0] cycles
);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_op_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(op_q));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we && !done));

    a_r9_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    a_r1_mem_only_idx: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (op_q[2:0] == MEM_IDX));

    a_r1_reg_only_idx: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (op_q[2:0] != MEM_IDX));

    a_r6_test_no_write: assert property (@(posedge clk) disable iff (rst)
        (rf_we || (mem_req && mem_we)) |-> (op_q[7:6] != 2'b01));

    a_r8_cycle_range: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles >= CYC_W'(2) && cycles <= CYC_W'(4)));
endmodule

bind bitop_exec bitop_exec_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .rf_we    (rf_we),
    .op_q     (op_q),
    .cycles   (cycles)
);

// File: tb/bitop_exec_bench.sv
`timescale 1ns/1ps
module bitop_exec_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] ptr = '0;
    logic        busy, done;
    logic [3:0]  flags_out;
    logic [2:0]  cycles;
    logic [2:0]  rf_raddr, rf_waddr;
    logic [7:0]  rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  rf [8];
    logic [7:0]  mem_byte = '0;
    logic [15:0] last_raddr = '0, last_waddr = '0;
    int          rf_wr_cnt = 0, mem_wr_cnt = 0;

    always #10 clk = ~clk;

    bitop_exec u_bitop_exec (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .flags_in(flags_in),
        .ptr(ptr), .busy(busy), .done(done), .flags_out(flags_out), .cycles(cycles),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem_byte;

    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem_byte   <= mem_wdata;
                last_waddr <= mem_addr;
                mem_wr_cnt <= mem_wr_cnt + 1;
            end else begin
                last_raddr <= mem_addr;
            end
        end
        if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
            rf_wr_cnt    <= rf_wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model built from R2..R8; flags_in is {Z=1,N=1,H=0,C=cin}
    function automatic void model(input logic [7:0] op, input logic [7:0] d, input logic cin,
                                  output logic [7:0] r, output logic [3:0] f,
                                  output int cy, output logic wr);
        logic c;
        logic [2:0] s;
        s  = op[5:3];
        f  = {1'b1, 1'b1, 1'b0, cin};
        r  = d;
        wr = (op[7:6] != 2'b01);
        c  = 1'b0;
        case (op[7:6])
            2'b00: begin
                case (s)
                    3'd0: begin c = d[7]; r = (d << 1) | {7'd0, d[7]}; end
                    3'd1: begin c = d[0]; r = (d >> 1) | {d[0], 7'd0}; end
                    3'd2: begin c = d[7]; r = (d << 1) | {7'd0, cin}; end
                    3'd3: begin c = d[0]; r = (d >> 1) | {cin, 7'd0}; end
                    3'd4: begin c = d[7]; r = d << 1; end
                    3'd5: begin c = d[0]; r = (d >> 1) | (d & 8'h80); end
                    3'd6: begin c = 1'b0; r = {d[3:0], d[7:4]}; end
                    default: begin c = d[0]; r = d >> 1; end
                endcase
                f = {(r == 8'h00), 1'b0, 1'b0, c};
            end
            2'b01: f = {~d[s], 1'b0, 1'b1, cin};
            2'b10: r = d & ~(8'h01 << s);
            default: r = d | (8'h01 << s);
        endcase
        if (op[2:0] != 3'd6) cy = 2;
        else if (wr)         cy = 4;
        else                 cy = 3;
    endfunction

    function automatic string res_req(input logic [7:0] op);
        if (op[7:6] == 2'b00) return (op[5:3] < 3'd4) ? "R3" : "R4";
        if (op[7:6] == 2'b01) return "R2/R6";
        return "R2/R7";
    endfunction

    function automatic string flg_req(input logic [7:0] op);
        if (op[7:6] == 2'b00) return "R5";
        if (op[7:6] == 2'b01) return "R6";
        return "R7";
    endfunction

    task automatic run_op(input logic [7:0] op, input logic [7:0] d, input logic cin, input bit poke);
        logic [7:0] er, act_r, other;
        logic [3:0] ef;
        int ecy, wd;
        logic ewr, is_mem;
        logic [15:0] p;
        is_mem = (op[2:0] == 3'd6);
        model(op, d, cin, er, ef, ecy, ewr);
        @(negedge clk);
        for (int i = 0; i < 8; i++) rf[i] = 8'(i * 37 + 11);
        if (!is_mem) rf[op[2:0]] = d;
        mem_byte   = is_mem ? d : 8'h5A;
        other      = is_mem ? rf[0] : 8'h5A;
        rf_wr_cnt  = 0;
        mem_wr_cnt = 0;
        p          = 16'(($urandom & 16'hFFFF) | 16'h0001);
        ptr        = p;
        opcode     = op;
        flags_in   = {1'b1, 1'b1, 1'b0, cin};
        start      = 1'b1;
        @(negedge clk);
        chk("R10", "busy after start", int'(busy), 1);
        ptr = ~p;
        if (poke) begin
            opcode   = op ^ 8'hC7;
            flags_in = 4'b0000;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        wd = 0;
        while (!done && wd < 50) begin
            @(negedge clk);
            wd++;
        end
        chk("R10", "done reached", int'(done), 1);
        act_r = is_mem ? mem_byte : rf[op[2:0]];
        chk(res_req(op), $sformatf("result op %02h", op), int'(act_r), int'(er));
        chk(flg_req(op), $sformatf("flags op %02h", op), int'(flags_out), int'(ef));
        chk("R8", $sformatf("cycles op %02h", op), int'(cycles), ecy);
        if (ewr) chk("R7", "write count", rf_wr_cnt + mem_wr_cnt, 1);
        else     chk("R6", "no write", rf_wr_cnt + mem_wr_cnt, 0);
        if (is_mem) begin
            chk("R1", "register untouched by memory op", int'(rf[0]), int'(other));
            chk("R9", "read address", int'(last_raddr), int'(p));
            if (ewr) chk("R9", "write address", int'(last_waddr), int'(p));
        end else begin
            chk("R1", "memory untouched by register op", int'(mem_byte), int'(other));
            chk("R1", "no memory write", mem_wr_cnt, 0);
        end
        @(negedge clk);
        chk("R10", "done one cycle", int'(done), 0);
        chk("R10", "idle after done", int'(busy), 0);
    endtask

    // {op, operand, cin, result, flags, cycles}
    localparam logic [31:0] VEC [13] = '{
        {8'h00, 8'h85, 1'b0, 8'h0B, 4'b0001, 3'd2},
        {8'h09, 8'h01, 1'b0, 8'h80, 4'b0001, 3'd2},
        {8'h12, 8'h80, 1'b0, 8'h00, 4'b1001, 3'd2},
        {8'h1B, 8'h01, 1'b1, 8'h80, 4'b0001, 3'd2},
        {8'h24, 8'hFF, 1'b0, 8'hFE, 4'b0001, 3'd2},
        {8'h2D, 8'h81, 1'b0, 8'hC0, 4'b0001, 3'd2},
        {8'h37, 8'hF0, 1'b1, 8'h0F, 4'b0000, 3'd2},
        {8'h3E, 8'h01, 1'b0, 8'h00, 4'b1001, 3'd4},
        {8'h78, 8'h7F, 1'b1, 8'h7F, 4'b1011, 3'd2},
        {8'h46, 8'h01, 1'b0, 8'h01, 4'b0010, 3'd3},
        {8'h9A, 8'hFF, 1'b0, 8'hF7, 4'b1100, 3'd2},
        {8'hEE, 8'h00, 1'b1, 8'h20, 4'b1101, 3'd4},
        {8'h36, 8'h00, 1'b1, 8'h00, 4'b1000, 3'd4}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        chk("R11", "busy in reset", int'(busy), 0);
        chk("R11", "done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "no mem request idle", int'(mem_req), 0);
        chk("R11", "no reg write idle", int'(rf_we), 0);

        // Table vectors checked against hand-computed values (R3 R4 R5 R6 R7 R8)
        for (int v = 0; v < 13; v++) begin
            logic [7:0] r, ref_r;
            logic [3:0] f;
            int cy;
            logic wr;
            model(VEC[v][31:24], VEC[v][23:16], VEC[v][15], ref_r, f, cy, wr);
            r = VEC[v][14:7];
            chk("R5", $sformatf("table model flags %0d", v), int'(f), int'(VEC[v][6:3]));
            chk("R8", $sformatf("table model cycles %0d", v), cy, int'(VEC[v][2:0]));
            chk("R3", $sformatf("table model result %0d", v), int'(ref_r), int'(r));
            run_op(VEC[v][31:24], VEC[v][23:16], VEC[v][15], 1'b0);
        end

        // Exhaustive opcode sweep with random operands and both carries
        for (int op = 0; op < 256; op++) begin
            run_op(8'(op), 8'($urandom), 1'b0, 1'b0);
            run_op(8'(op), 8'($urandom), 1'b1, 1'b0);
        end

        // Corner cases: all-zero and all-one operands, start while busy (R10)
        run_op(8'h06, 8'h00, 1'b1, 1'b0);
        run_op(8'hFF, 8'hFF, 1'b0, 1'b0);
        run_op(8'h86, 8'h01, 1'b0, 1'b1);
        run_op(8'h11, 8'h7F, 1'b1, 1'b1);
        run_op(8'h4E, 8'h00, 1'b1, 1'b1);

        summary();
    end
endmodule